// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master of an Ethernet MAC. It runs IEEE clause 22 read and write transactions to an external PHY over the two-wire management interface. Software sees two 16-bit registers: a command word and a data word. A single write to the command word names the PHY, names the register inside that PHY and selects the direction. The same write launches the frame. Software then polls the busy bit in that word until it clears.

For a write, software places the value in the data word before issuing the command. For a read, the data word holds the 16 bits returned by the PHY once busy drops. The management clock runs only while a frame is in flight and is produced by dividing the system clock. The block changes the serial data line when the management clock falls and samples it when the clock rises. The register access port carries no data stream, so it is a plain one-cycle write strobe with combinational read-back and has no valid/ready handshake.

Top module: `mdio_master`

## Requirements
- R1: After reset the command read-back and the data read-back are both 0, `mdc` is low and `mdio_oe` is low.
- R2: A command write (`reg_wr`=1, `reg_addr`=0) while idle sets the busy bit (bit 0 of `ctrl_rdata`) on the next cycle. Busy stays set for exactly 128·DIV_HALF system clock cycles. While it is set, `ctrl_rdata` returns the PHY address in bits 15:11, the register address in bits 10:6 and the direction in bit 1. Bits 5:2 read as 0.
- R3: Each frame has 64 bits, sent MSB first: 32 ones, start bits 01, an opcode of 10 for a read or 01 for a write (command bit 1 = 1 selects write), the 5-bit PHY address taken from command bits 15:11, and the 5-bit register address taken from command bits 10:6.
- R4: On a write the master drives all 64 bits. The turnaround bits are 1 then 0, and they are followed by the 16-bit data word loaded before the command.
- R5: On a read the master drives `mdio_oe` low for the two turnaround bits and the 16 data bits. It samples 16 data bits MSB first. When busy clears, the data read-back holds those bits.
- R6: During a frame `mdc` stays high for DIV_HALF cycles and low for DIV_HALF cycles in each period, and a frame has exactly 64 rising edges. While idle, `mdc` stays low.
- R7: During a frame, `mdio_o` changes only on a falling edge of `mdc`.
- R8: A command write that arrives while busy is set is ignored. The read-back fields, the frame on the wire and the busy length are unaffected.
- R9: A data write (`reg_wr`=1, `reg_addr`=1) while idle replaces the data read-back with all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | 0 selects the command word, 1 selects the data word |
| reg_wdata | input | 16 | Write value |
| ctrl_rdata | output | 16 | Command word read-back, with busy in bit 0 |
| data_rdata | output | 16 | Data word read-back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Serial data seen on the pad |

## Verification
The bench builds the block with DIV_HALF = 2, so every frame takes 256 system cycles. At that length a table of seven transactions fits easily, together with a command that is fired into the middle of a read. The divisor of 2 also gives a high phase and a low phase that span more than one sample. This makes a data change at a rising edge, or inside a phase, visible to the bench's phase monitor. The all-ones and all-zeros corner values for address and data are in the table.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;   // first turnaround bit
  localparam int DATA_POS  = TA_POS + 2;                 // first data bit
  localparam int IDX_W     = $clog2(FRAME_LEN);
  // command word field positions
  localparam int PHY_LSB   = 11;
  localparam int REG_LSB   = 6;
  localparam int DIR_BIT   = 1;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic              wr;
  } mdio_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c,
                                                       logic [DATA_W-1:0] wd);
    logic [1:0]        op;
    logic [DATA_W+1:0] tail;
    op   = c.wr ? 2'b01 : 2'b10;
    tail = c.wr ? {2'b10, wd} : '0;
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regn, tail};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last     = (cnt == CW'(DIV_HALF - 1));
  assign rise_now = run && last && !mdc;
  assign fall_now = run && last && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_now,
  input  logic              fall_now,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] frame_q;
  logic [IDX_W-1:0]     idx;
  logic                 wr_q;

  assign done    = busy && fall_now && (idx == IDX_LAST);
  assign mdio_o  = busy && frame_q[IDX_LAST - idx];
  assign mdio_oe = busy && (wr_q || (idx < IDX_W'(TA_POS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx     <= '0;
      wr_q    <= 1'b0;
      busy    <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        frame_q <= build_frame(cmd, wdata);
        idx     <= '0;
        wr_q    <= cmd.wr;
        busy    <= 1'b1;
      end
    end else begin
      if (rise_now && !wr_q && (idx >= IDX_W'(DATA_POS)))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall_now) begin
        if (idx == IDX_LAST) busy <= 1'b0;
        else                 idx  <= idx + 1'b1;
      end
    end
  end

  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t         cmd_q, cmd_new;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_data;
  logic              busy, start, done, rise_now, fall_now;

  assign cmd_new.phy  = reg_wdata[PHY_LSB +: ADDR_W];
  assign cmd_new.regn = reg_wdata[REG_LSB +: ADDR_W];
  assign cmd_new.wr   = reg_wdata[DIR_BIT];
  assign start        = reg_wr && !reg_addr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (start) cmd_q <= cmd_new;
      if (done && !cmd_q.wr)       data_q <= rd_data;
      else if (reg_wr && reg_addr) data_q <= reg_wdata;
    end
  end

  assign ctrl_rdata = {cmd_q.phy, cmd_q.regn, 4'b0000, cmd_q.wr, busy};
  assign data_rdata = data_q;

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_now(rise_now), .fall_now(fall_now)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_new), .wdata(data_q),
    .rise_now(rise_now), .fall_now(fall_now), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rd_data(rd_data)
  );

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !ctrl_rdata[0]) |=> ctrl_rdata[0]);

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[0] && reg_wr && !reg_addr) |=> $stable(ctrl_rdata[15:1]));

  assert_drive_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $changed(mdio_o)) |-> $fell(mdc));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int D       = 2;
  localparam int BUSY_CY = 128 * D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;

  int total = 0;
  int bad   = 0;

  always #2ns clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_master #(.DIV_HALF(D)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // wire monitor and PHY model
  logic [63:0] cap = '0, oe_cap = '0;
  int rise_cnt = 0, rise_base = 0;
  logic [15:0] phy_val = '0;

  always @(posedge mdc) begin
    cap      <= {cap[62:0], mdio_o};
    oe_cap   <= {oe_cap[62:0], mdio_oe};
    rise_cnt <= rise_cnt + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_cnt - rise_base;
    if (k >= 48 && k <= 63) phy_drv <= phy_val[63-k];
    else                    phy_drv <= 1'b1;
  end

  // phase monitor for R6 and R7
  int hi_cnt = 0, r7_viol = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b0;
  always @(negedge clk) begin
    if (mdc) hi_cnt <= hi_cnt + 1;
    if (mdc && prev_mdc && (mdio_o != prev_o)) r7_viol <= r7_viol + 1;
    prev_mdc <= mdc;
    prev_o   <= mdio_o;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (ctrl_rdata[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  // one full transaction with all checks
  task automatic do_txn(input logic w, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] wd, input logic [15:0] rv);
    int cyc, hi0;
    logic [63:0] exp_f, exp_oe;
    logic [15:0] exp_ctrl;
    if (w) reg_write(1'b1, wd);
    phy_val   = rv;
    rise_base = rise_cnt;
    hi0       = hi_cnt;
    exp_ctrl  = {p, r, 4'b0000, w, 1'b1};
    reg_write(1'b0, {p, r, 4'b0000, w, 1'b0});
    check("R2 ctrl readback while busy", 64'(ctrl_rdata), 64'(exp_ctrl));
    wait_idle(cyc);
    check("R2 busy length", 64'(cyc), 64'(BUSY_CY));
    check("R6 rising edges per frame", 64'(rise_cnt - rise_base), 64'd64);
    check("R6 mdc high cycles", 64'(hi_cnt - hi0), 64'(64 * D));
    check("R6 mdc idle low", 64'(mdc), 64'd0);
    exp_f  = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
              (w ? {2'b10, wd} : 18'h0)};
    exp_oe = w ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    check("R3 frame header", 64'(cap[63:18]), 64'(exp_f[63:18]));
    if (w) begin
      check("R4 turnaround and data", 64'(cap[17:0]), 64'(exp_f[17:0]));
      check("R4 drive enable", oe_cap, exp_oe);
      check("R4 data word kept", 64'(data_rdata), 64'(wd));
    end else begin
      check("R5 release pattern", oe_cap, exp_oe);
      check("R5 read data", 64'(data_rdata), 64'(rv));
    end
  endtask

  // wr, phy, reg, wdata, rdval
  localparam logic [42:0] VEC [7] = '{
    {1'b1, 5'd1,  5'd0,  16'h1234, 16'h0000},
    {1'b0, 5'd1,  5'd2,  16'h0000, 16'h8001},
    {1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
    {1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000},
    {1'b0, 5'd31, 5'd31, 16'h0000, 16'hFFFF},
    {1'b1, 5'd10, 5'd21, 16'hA55A, 16'h0000},
    {1'b0, 5'd21, 5'd10, 16'h0000, 16'h5AC3}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl after reset", 64'(ctrl_rdata), 64'd0);
    check("R1 data after reset", 64'(data_rdata), 64'd0);
    check("R1 mdc/oe after reset", 64'({mdc, mdio_oe}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++)
      do_txn(VEC[i][42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0]);

    // R9 data write while idle
    reg_write(1'b1, 16'hC3A5);
    check("R9 data readback", 64'(data_rdata), 64'hC3A5);

    // R8 command during a read is ignored
    begin
      int cyc;
      phy_val   = 16'h0F0F;
      rise_base = rise_cnt;
      reg_write(1'b0, {5'd3, 5'd4, 4'b0000, 1'b0, 1'b0});
      repeat (20) @(negedge clk);
      reg_write(1'b0, {5'd7, 5'd9, 4'b0000, 1'b1, 1'b0});
      check("R8 ctrl unchanged", 64'(ctrl_rdata), 64'({5'd3, 5'd4, 4'b0000, 1'b0, 1'b1}));
      wait_idle(cyc);
      check("R8 busy not restarted", 64'(cyc + 22), 64'(BUSY_CY));
      check("R8 frame addresses", 64'(cap[29:18]), 64'({2'b10, 5'd3, 5'd4}));
      check("R8 read data", 64'(data_rdata), 64'h0F0F);
      check("R8 no second frame", 64'(ctrl_rdata[0]), 64'd0);
    end

    check("R7 mdio steady outside falling edges", 64'(r7_viol), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule